// File: doc/BRIEF.md
# Interrupt Status, Clear and Enable Unit

This block gathers the event and state flags of a card host controller into one 32-bit status word, lets software clear event flags one bit at a time, selects through an enable word which flags may raise the controller's interrupt, and drives a single level-sensitive interrupt line. The command and data paths feed it single-cycle event pulses and continuous state levels. A small register port writes the clear and enable words and reads back the status and enable words.

The status word has two kinds of bits. Sticky event bits (positions 0 to 11 and 21 to 28) are set by a pulse and held until software writes a one to the same position of the clear word. Live state bits (positions 12 to 20) hold no history. They show their source one cycle late, and clear writes do not touch them. Positions 29 to 31 have no source. Some fixed bit positions carry defined meanings:

| Position | Meaning |
|----------|---------|
| 0 | Command CRC error |
| 1 | Data CRC error |
| 2 | Command timeout |
| 3 | Data timeout |
| 4 | Transmit underrun |
| 5 | Receive overrun |
| 6 | Good response received |
| 7 | Command sent with no response expected |
| 8 | Data end |
| 20 | Data line 0 busy |
| 22 | Card interrupt |

A driver's normal start-up writes an all-zero enable word and then writes all ones to the clear word.

Top module: `irq_status_unit`

## Requirements
- R1: While reset is asserted, the status word, the enable word, the read data and the interrupt line are all zero.
- R2: A pulse on `evt_i` at a sticky position (0 to 11 or 21 to 28) sets that status bit on the next clock edge. The bit then stays set until it is cleared.
- R3: A write with `wr_en_i` high and `addr_i` = 1 (clear word) clears, on the next edge, every sticky status bit whose position holds a one in `wdata_i`. Sticky bits at positions holding a zero keep their value.
- R4: Status bits 12 to 20 equal `live_i` at the same positions one cycle earlier. A clear write has no effect on them.
- R5: When an event pulse and a clear write hit the same sticky bit in the same cycle, the bit ends set.
- R6: Status bits 29 to 31 and enable bits 29 to 31 always read zero. `evt_i` at positions 12 to 20 and 29 to 31 has no effect. `live_i` outside positions 12 to 20 has no effect.
- R7: A write with `addr_i` = 2 loads the enable word from `wdata_i` on the next edge. `irq_o` is high exactly when some bit position is set in both the status word and the enable word, with no extra delay after those registers.
- R8: Enable bits act independently. With only bit 22 (card interrupt) enabled, every other flag leaves `irq_o` low, and setting bit 22 raises it.
- R9: `rdata_o` shows the status word when `addr_i` = 0 and the enable word when `addr_i` = 2. It shows zero when `addr_i` = 1 or 3. A write to address 0 or 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Single-cycle event pulses, one per sticky position |
| live_i | input | 32 | Live state levels, used at positions 12 to 20 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 status, 1 clear, 2 enable |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from registers |
| status_o | output | 32 | Status word |
| mask_o | output | 32 | Enable word |
| irq_o | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check these behaviours:
- An event always lands in its sticky bit, and a set bit survives until it is explicitly cleared.
- A clear removes only the bits it names, except where a same-cycle event overrides it.
- The live field tracks its source with one cycle of lag.
- The unused positions stay zero.
- The interrupt changes only when the status or enable word changes.

Only the bench's scenarios can show the rest:
- The full per-position sweeps, which prove that each position belongs to the right class.
- The read-address decode.
- The card-interrupt-only enable case.
- The exact interrupt value for each single-bit enable against a full status word.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned STAT_W  = 32;
  localparam int unsigned LIVE_LO = 12;
  localparam int unsigned LIVE_HI = 20;
  localparam int unsigned TOP_BIT = 28;

  // Named flag positions used by software
  localparam int unsigned POS_CMD_CRC  = 0;
  localparam int unsigned POS_DAT_CRC  = 1;
  localparam int unsigned POS_CMD_TO   = 2;
  localparam int unsigned POS_DAT_TO   = 3;
  localparam int unsigned POS_TX_UNDER = 4;
  localparam int unsigned POS_RX_OVER  = 5;
  localparam int unsigned POS_RESP_OK  = 6;
  localparam int unsigned POS_SENT     = 7;
  localparam int unsigned POS_DAT_END  = 8;
  localparam int unsigned POS_D0_BUSY  = 20;
  localparam int unsigned POS_CARD_IRQ = 22;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CLEAR  = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_NONE   = 2'd3
  } isc_sel_e;

  function automatic logic [STAT_W-1:0] span(input int unsigned lo, input int unsigned hi);
    logic [STAT_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < STAT_W; i++)
      if (i >= lo && i <= hi) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [STAT_W-1:0] IMPL_BITS   = span(0, TOP_BIT);
  localparam logic [STAT_W-1:0] LIVE_BITS   = span(LIVE_LO, LIVE_HI);
  localparam logic [STAT_W-1:0] STICKY_BITS = IMPL_BITS & ~LIVE_BITS;

  // Next value of one sticky flag: a set outranks a clear
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic any_enabled(input logic [STAT_W-1:0] st, input logic [STAT_W-1:0] en);
    return |(st & en);
  endfunction
endpackage

// File: rtl/isc_sticky_bank.sv
module isc_sticky_bank #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] KEEP = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  import isc_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (KEEP[i]) begin : g_flop
      always_ff @(posedge clk) begin
        if (!rst_n) q[i] <= 1'b0;
        else        q[i] <= sticky_next(q[i], set_vec[i], clr_vec[i]);
      end
    end else begin : g_tie
      logic unused_in;
      assign unused_in = set_vec[i] ^ clr_vec[i];
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/isc_live_stage.sv
module isc_live_stage #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] KEEP = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= lvl & KEEP;
  end
endmodule

// File: rtl/isc_enable_reg.sv
module isc_enable_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] KEEP = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din & KEEP;
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import isc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] evt_i,
  input  logic [31:0] live_i,
  input  logic        wr_en_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic [31:0] status_o,
  output logic [31:0] mask_o,
  output logic        irq_o
);
  // Named internal events
  logic              clr_wr;
  logic              en_wr;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] sticky_q;
  logic [STAT_W-1:0] live_q;
  logic [STAT_W-1:0] en_q;
  isc_sel_e          sel;

  assign sel     = isc_sel_e'(addr_i);
  assign clr_wr  = wr_en_i && (sel == SEL_CLEAR);
  assign en_wr   = wr_en_i && (sel == SEL_ENABLE);
  assign clr_vec = clr_wr ? wdata_i : '0;
  assign set_vec = evt_i;

  isc_sticky_bank #(.W(STAT_W), .KEEP(STICKY_BITS)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .q(sticky_q)
  );

  isc_live_stage #(.W(STAT_W), .KEEP(LIVE_BITS)) u_live (
    .clk(clk), .rst_n(rst_n), .lvl(live_i), .q(live_q)
  );

  isc_enable_reg #(.W(STAT_W), .KEEP(IMPL_BITS)) u_enable (
    .clk(clk), .rst_n(rst_n), .load(en_wr), .din(wdata_i), .q(en_q)
  );

  assign status_o = sticky_q | live_q;
  assign mask_o   = en_q;
  assign irq_o    = any_enabled(status_o, en_q);

  always_comb begin
    unique case (sel)
      SEL_STATUS: rdata_o = status_o;
      SEL_ENABLE: rdata_o = en_q;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
  import isc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] evt_i,
  input logic [31:0] live_i,
  input logic [31:0] clr_vec,
  input logic        en_wr,
  input logic [31:0] wdata_i,
  input logic [31:0] status_o,
  input logic [31:0] mask_o,
  input logic        irq_o
);
  assert_event_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & $past(evt_i & STICKY_BITS)) == $past(evt_i & STICKY_BITS)));

  assert_flag_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_o) & STICKY_BITS & ~$past(clr_vec)) & ~status_o) == '0));

  assert_clear_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & $past(clr_vec & ~evt_i) & STICKY_BITS) == '0));

  assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & $past(clr_vec & evt_i & STICKY_BITS)) == $past(clr_vec & evt_i & STICKY_BITS)));

  assert_live_lags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & LIVE_BITS) == $past(live_i & LIVE_BITS)));

  assert_spare_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[31:29] == 3'b000) && (mask_o[31:29] == 3'b000));

  assert_irq_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(status_o) && $stable(mask_o)) |-> $stable(irq_o));

  assert_zero_enable_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && wdata_i == '0) |=> !irq_o);
endmodule

bind irq_status_unit irq_status_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .live_i(live_i), .clr_vec(clr_vec),
  .en_wr(en_wr), .wdata_i(wdata_i), .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
);

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_i = '0, live_i = '0, wdata_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] rdata_o, status_o, mask_o;
  logic        irq_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] stk, lv, impl;
  logic [31:0] m_st, m_lv, m_en;

  always #10 clk = ~clk;

  irq_status_unit u_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .live_i(live_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .status_o(status_o),
    .mask_o(mask_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    if (a == 2'd0) return m_st | m_lv;
    if (a == 2'd2) return m_en;
    return 32'h0;
  endfunction

  task automatic compare_all(input string tag);
    check({tag, " status"}, status_o, m_st | m_lv);
    check({tag, " enable"}, mask_o, m_en);
    check({tag, " irq"}, {31'b0, irq_o}, {31'b0, |((m_st | m_lv) & m_en)});
    check({tag, " rdata"}, rdata_o, exp_rd(addr_i));
  endtask

  // Called at a falling edge; drives, waits one full cycle, updates model, compares
  task automatic step(input string tag, input logic [31:0] ev, input logic [31:0] lvv,
                      input logic we, input logic [1:0] a, input logic [31:0] wd);
    evt_i = ev; live_i = lvv; wr_en_i = we; addr_i = a; wdata_i = wd;
    @(negedge clk);
    m_st = (m_st & ~((we && a == 2'd1) ? wd : 32'h0)) | (ev & stk);
    m_lv = lvv & lv;
    if (we && a == 2'd2) m_en = wd & impl;
    evt_i = '0; wr_en_i = 1'b0;
    compare_all(tag);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    stk = '0; lv = '0; impl = '0;
    for (int b = 0; b < 32; b++) begin
      if (b <= 28) impl[b] = 1'b1;
      if (b >= 12 && b <= 20) lv[b] = 1'b1;
      else if (b <= 28) stk[b] = 1'b1;
    end
    m_st = '0; m_lv = '0; m_en = '0;

    // R1: reset state, even with sources driven
    evt_i = '1; live_i = '1;
    repeat (3) @(negedge clk);
    compare_all("R1 reset");
    evt_i = '0; live_i = '0;
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after release");

    // R1/R3: driver start-up sequence
    step("R1 init enable", '0, '0, 1'b1, 2'd2, 32'h0);
    step("R3 init clear", '0, '0, 1'b1, 2'd1, 32'hFFFF_FFFF);

    // R2/R3/R6: per-position set, hold, clear
    for (int b = 0; b < 32; b++) begin
      step("R2 R6 set", 32'h1 << b, '0, 1'b0, 2'd0, '0);
      step("R2 hold", '0, '0, 1'b0, 2'd0, '0);
      step("R3 clear other", '0, '0, 1'b1, 2'd1, ~(32'h1 << b));
      step("R3 clear own", '0, '0, 1'b1, 2'd1, 32'h1 << b);
    end

    // R4/R6: live field tracking, immune to clear-all
    step("R2 fill sticky", '1, '0, 1'b0, 2'd0, '0);
    for (int b = 0; b < 32; b++)
      step("R4 R6 live", '0, 32'h1 << b, 1'b1, 2'd1, 32'hFFFF_FFFF);
    step("R4 live all", '0, '1, 1'b1, 2'd1, 32'hFFFF_FFFF);
    step("R4 live drop", '0, '0, 1'b0, 2'd0, '0);

    // R5: event and clear on the same position in the same cycle
    for (int b = 0; b < 32; b++)
      step("R5 collide", 32'h1 << b, '0, 1'b1, 2'd1, 32'hFFFF_FFFF);

    // R6/R7: single-bit enable against full status
    step("R2 fill", '1, '1, 1'b0, 2'd0, '0);
    for (int b = 0; b < 32; b++)
      step("R6 R7 enable bit", '0, '1, 1'b1, 2'd2, 32'h1 << b);
    step("R7 enable none", '0, '1, 1'b1, 2'd2, 32'h0);
    step("R7 enable all", '0, '0, 1'b1, 2'd2, 32'hFFFF_FFFF);

    // R8: only the card interrupt enabled
    step("R8 clear all", '0, '0, 1'b1, 2'd1, 32'hFFFF_FFFF);
    step("R8 enable card", '0, '0, 1'b1, 2'd2, 32'h0040_0000);
    step("R8 other flags", ~32'h0040_0000, '1, 1'b0, 2'd2, '0);
    check("R8 irq low", {31'b0, irq_o}, 32'h0);
    step("R8 card flag", 32'h0040_0000, '0, 1'b0, 2'd2, '0);
    check("R8 irq high", {31'b0, irq_o}, 32'h1);

    // R9: address decode, ignored writes
    step("R9 read status", '0, 32'h0001_0000, 1'b0, 2'd0, '0);
    step("R9 write status ignored", '0, 32'h0001_0000, 1'b1, 2'd0, 32'hFFFF_FFFF);
    step("R9 write none ignored", '0, 32'h0001_0000, 1'b1, 2'd3, 32'hFFFF_FFFF);
    step("R9 read clear addr", '0, 32'h0001_0000, 1'b0, 2'd1, '0);
    step("R9 read enable", '0, 32'h0001_0000, 1'b0, 2'd2, '0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule